// File: doc/BRIEF.md
# ATA Device Task-File Register Block

This block is the host-visible register file of one ATA/IDE device. A host bus presents a 4-bit register address, a read strobe, a write strobe and a 16-bit data word. Eight-bit task-file registers take the low byte of each write, and reads return a zero-extended byte through a combinational read multiplexer. The registers are error, features, sector count, sector number, cylinder low, cylinder high, device/head, status, command and device control. The data port and the command executor sit outside this block. The block hands the executor the command byte, the features byte and a one-cycle start pulse.

A command write always stores the byte. The start pulse is raised only when the device/head select bit matches the configured device index, or when the byte is the execute-diagnostics code. A small state machine follows the software-reset bit of device control. State `SR_IDLE` moves to `SR_HELD` on a device-control write that sets the bit (transition *enter*, which sets busy). State `SR_HELD` moves back to `SR_IDLE` on a device-control write that clears the bit (transition *leave*, which returns every register except device control to its power-on value). Any other write leaves the state unchanged: a device-control write that keeps the bit at its current value, or a write to another address.

Top module: `taskfile_regs`

## Requirements
- R1: After reset, reads return error 0x0001, sector count 0x0001, sector number 0x0001, cylinder low/high 0x0000, device/head 0x0000 and status 0x0050. BSY is bit 7, DRDY is bit 6 and DSC is bit 4. After reset cmd_start is 0, cmd_code is 0x00 and feat_val is 0x00.
- R2: A read at address 0 returns 0xFFFF. A write at address 0 changes no register.
- R3: Reads at address 7 (status) and address 14 (alternate status) return the same stored status byte.
- R4: Reads at addresses 8 to 13 and 15 return 0. Writes to those addresses change no register.
- R5: A write at address 1 stores the features byte, which appears on feat_val. A read at address 1 returns the error register, and that write leaves the error register unchanged.
- R6: A write at address 2 (sector count), 3 (sector number), 4 (cylinder low), 5 (cylinder high) or 6 (device/head) stores wdata[7:0]. A later read of that address returns the byte zero-extended to 16 bits.
- R7: A write at address 7 stores wdata[7:0] on cmd_code. It raises cmd_start for exactly the following cycle only if bit 4 of device/head equals dev_index, or if the byte is 0x90.
- R8: A write at address 14 always stores the device-control byte. When bit 2 of device control goes from 0 to 1, status bit 7 (BSY) is set. A write that keeps bit 2 at 1 changes nothing else.
- R9: When a write at address 14 takes bit 2 from 1 to 0, every register except device control returns to its R1 value, and BSY is cleared.
- R10: While rd_en is low, rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_index | input | 1 | This device's index: 0 for master, 1 for slave |
| addr | input | 4 | Register address |
| rd_en | input | 1 | Read strobe; rdata is valid in the same cycle |
| wr_en | input | 1 | Write strobe; the register takes the value at the clock edge |
| wdata | input | 16 | Write data; only the low byte is stored |
| rdata | output | 16 | Read data |
| cmd_start | output | 1 | One-cycle pulse that starts a command |
| cmd_code | output | 8 | Stored command byte |
| feat_val | output | 8 | Stored features byte |

## Verification
The device-control register cannot be read back, so the software-reset state machine can only be observed through its effects. The stimulus sets the reset bit and then rewrites it with the bit still set. It loads the other registers while the device is held, releases the bit, and checks that every readable register has returned to its power-on value. A second rise then proves that the stored control byte followed the release write, because busy is set again. Selection is exercised with both values of dev_index against both values of the select bit, and with the diagnostics code while the device is not selected.

// File: rtl/taskfile_pkg.sv
package taskfile_pkg;
    localparam int TF_ADDR_W = 4;
    typedef logic [TF_ADDR_W-1:0] tf_addr_t;

    // register addresses
    localparam tf_addr_t A_DATA    = 4'd0;
    localparam tf_addr_t A_ERRFEAT = 4'd1;
    localparam tf_addr_t A_SCNT    = 4'd2;
    localparam tf_addr_t A_DEVHD   = 4'd6;
    localparam tf_addr_t A_STATCMD = 4'd7;
    localparam tf_addr_t A_ALTCTL  = 4'd14;

    // number of plain read/write registers starting at A_SCNT
    localparam int PLAIN_N = 5;

    // bit positions
    localparam int ST_BUSY     = 7;
    localparam int ST_READY    = 6;
    localparam int ST_SEEKDONE = 4;
    localparam int DC_RESET    = 2;
    localparam int DH_DEVSEL   = 4;

    localparam logic [7:0] CMD_DIAG = 8'h90;

    typedef enum logic {
        SR_IDLE,
        SR_HELD
    } srst_state_e;
endpackage

// File: rtl/taskfile_srst_fsm.sv
module taskfile_srst_fsm
    import taskfile_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_wr,
    input  logic ctl_bit,
    output logic enter_evt,
    output logic leave_evt
);
    srst_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SR_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SR_IDLE: if (ctl_wr && ctl_bit)  state_d = SR_HELD;
            SR_HELD: if (ctl_wr && !ctl_bit) state_d = SR_IDLE;
            default: state_d = SR_IDLE;
        endcase
    end

    always_comb begin
        enter_evt = 1'b0;
        leave_evt = 1'b0;
        unique case (state_q)
            SR_IDLE: enter_evt = ctl_wr && ctl_bit;
            SR_HELD: leave_evt = ctl_wr && !ctl_bit;
            default: ;
        endcase
    end
endmodule

// File: rtl/taskfile_regbank.sv
module taskfile_regbank
    import taskfile_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  tf_addr_t                      addr,
    input  logic [REG_W-1:0]              wval,
    input  logic                          soft_clear,
    input  logic                          set_busy,
    output logic [REG_W-1:0]              err_q,
    output logic [REG_W-1:0]              feat_q,
    output logic [PLAIN_N-1:0][REG_W-1:0] plain_q,
    output logic [REG_W-1:0]              stat_q,
    output logic [REG_W-1:0]              devctl_q
);
    localparam logic [REG_W-1:0] ERR_RST  = REG_W'(1);
    localparam logic [REG_W-1:0] STAT_RST = REG_W'((1 << ST_READY) | (1 << ST_SEEKDONE));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q  <= ERR_RST;
            feat_q <= '0;
            stat_q <= STAT_RST;
        end else if (soft_clear) begin
            err_q  <= ERR_RST;
            feat_q <= '0;
            stat_q <= STAT_RST;
        end else begin
            if (wr_en && addr == A_ERRFEAT) feat_q <= wval;
            if (set_busy) stat_q[ST_BUSY] <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          devctl_q <= '0;
        else if (wr_en && addr == A_ALTCTL)  devctl_q <= wval;
    end

    for (genvar gi = 0; gi < PLAIN_N; gi++) begin : g_plain
        localparam logic [REG_W-1:0] RV = (gi < 2) ? REG_W'(1) : '0;
        localparam tf_addr_t         RA = tf_addr_t'(A_SCNT + gi);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  plain_q[gi] <= RV;
            else if (soft_clear)         plain_q[gi] <= RV;
            else if (wr_en && addr == RA) plain_q[gi] <= wval;
        end
    end
endmodule

// File: rtl/taskfile_cmd_issue.sv
module taskfile_cmd_issue
    import taskfile_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [REG_W-1:0] wval,
    input  logic             sel_bit,
    input  logic             dev_index,
    input  logic             soft_clear,
    output logic [REG_W-1:0] cmd_q,
    output logic             start_q
);
    logic may_start;
    assign may_start = (sel_bit == dev_index) || (wval == REG_W'(CMD_DIAG));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q   <= '0;
            start_q <= 1'b0;
        end else begin
            start_q <= cmd_wr && may_start;
            if (soft_clear)  cmd_q <= '0;
            else if (cmd_wr) cmd_q <= wval;
        end
    end
endmodule

// File: rtl/taskfile_rdmux.sv
module taskfile_rdmux
    import taskfile_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int REG_W  = 8
) (
    input  logic                          rd_en,
    input  tf_addr_t                      addr,
    input  logic [REG_W-1:0]              err_q,
    input  logic [PLAIN_N-1:0][REG_W-1:0] plain_q,
    input  logic [REG_W-1:0]              stat_q,
    output logic [DATA_W-1:0]             rdata
);
    localparam int PAD_W = DATA_W - REG_W;

    logic [REG_W-1:0] byte_sel;
    logic             wide_ones;

    always_comb begin
        byte_sel  = '0;
        wide_ones = 1'b0;
        case (addr)
            A_DATA:               wide_ones = 1'b1;
            A_ERRFEAT:            byte_sel  = err_q;
            4'd2:                 byte_sel  = plain_q[0];
            4'd3:                 byte_sel  = plain_q[1];
            4'd4:                 byte_sel  = plain_q[2];
            4'd5:                 byte_sel  = plain_q[3];
            4'd6:                 byte_sel  = plain_q[4];
            A_STATCMD, A_ALTCTL:  byte_sel  = stat_q;
            default:              byte_sel  = '0;
        endcase
    end

    always_comb begin
        if (!rd_en)        rdata = '0;
        else if (wide_ones) rdata = '1;
        else               rdata = {{PAD_W{1'b0}}, byte_sel};
    end
endmodule

// File: rtl/taskfile_regs.sv
module taskfile_regs
    import taskfile_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int REG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dev_index,
    input  logic [3:0]        addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              cmd_start,
    output logic [REG_W-1:0]  cmd_code,
    output logic [REG_W-1:0]  feat_val
);
    logic [REG_W-1:0]              wval;
    logic                          unused_hi;
    logic                          ctl_wr, cmd_wr;
    logic                          enter_evt, leave_evt;
    logic [REG_W-1:0]              err_q, stat_q, devctl_q;
    logic [PLAIN_N-1:0][REG_W-1:0] plain_q;

    assign wval      = wdata[REG_W-1:0];
    assign unused_hi = ^wdata[DATA_W-1:REG_W] ^ ^devctl_q;
    assign ctl_wr    = wr_en && addr == A_ALTCTL;
    assign cmd_wr    = wr_en && addr == A_STATCMD;

    taskfile_srst_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_wr),
        .ctl_bit   (wval[DC_RESET]),
        .enter_evt (enter_evt),
        .leave_evt (leave_evt)
    );

    taskfile_regbank #(.REG_W(REG_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .addr       (addr),
        .wval       (wval),
        .soft_clear (leave_evt),
        .set_busy   (enter_evt),
        .err_q      (err_q),
        .feat_q     (feat_val),
        .plain_q    (plain_q),
        .stat_q     (stat_q),
        .devctl_q   (devctl_q)
    );

    taskfile_cmd_issue #(.REG_W(REG_W)) u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_wr     (cmd_wr),
        .wval       (wval),
        .sel_bit    (plain_q[A_DEVHD - A_SCNT][DH_DEVSEL]),
        .dev_index  (dev_index),
        .soft_clear (leave_evt),
        .cmd_q      (cmd_code),
        .start_q    (cmd_start)
    );

    taskfile_rdmux #(.DATA_W(DATA_W), .REG_W(REG_W)) u_rd (
        .rd_en   (rd_en),
        .addr    (addr),
        .err_q   (err_q),
        .plain_q (plain_q),
        .stat_q  (stat_q),
        .rdata   (rdata)
    );
endmodule

// File: rtl/taskfile_regs_chk.sv
module taskfile_regs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  addr,
    input logic        wr_en,
    input logic [15:0] wdata,
    input logic        cmd_start,
    input logic [7:0]  stat_q,
    input logic [7:0]  devctl_q
);
    // R7: a start pulse follows only a command write
    p_start_after_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |-> $past(wr_en && addr == 4'd7));

    // R8: rising reset bit sets busy
    p_busy_on_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 4'd14 && wdata[2] && !devctl_q[2]) |=> stat_q[7]);

    // R8: busy is raised by nothing but a reset-bit write
    p_busy_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q[7]) |-> $past(wr_en && addr == 4'd14 && wdata[2]));

    // R8: control byte follows every control write
    p_ctl_stored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 4'd14) |=> devctl_q == $past(wdata[7:0]));

    // R9: falling reset bit restores power-on status
    p_clear_on_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 4'd14 && !wdata[2] && devctl_q[2]) |=> stat_q == 8'h50);

    // R4: unmapped writes leave status and control alone
    p_unmapped_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr > 4'd7 && addr != 4'd14) |=> ($stable(stat_q) && $stable(devctl_q)));
endmodule

bind taskfile_regs taskfile_regs_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .wr_en     (wr_en),
    .wdata     (wdata),
    .cmd_start (cmd_start),
    .stat_q    (stat_q),
    .devctl_q  (devctl_q)
);

// File: tb/taskfile_regs_tb.sv
`timescale 1ns/1ps
module taskfile_regs_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dev_index = 1'b0;
    logic [3:0]  addr = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        cmd_start;
    logic [7:0]  cmd_code, feat_val;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // behavioural model state
    int m_reg[16];
    int m_dc, m_cmd, m_feat;
    bit m_start;

    always #4 clk = ~clk;

    taskfile_regs u_dut (
        .clk(clk), .rst_n(rst_n), .dev_index(dev_index), .addr(addr),
        .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
        .cmd_start(cmd_start), .cmd_code(cmd_code), .feat_val(feat_val)
    );

    task automatic model_reset_regs();
        for (int i = 0; i < 16; i++) m_reg[i] = 0;
        m_reg[1] = 1; m_reg[2] = 1; m_reg[3] = 1;
        m_reg[7] = 'h50;
        m_cmd = 0; m_feat = 0;
    endtask

    function automatic int model_read(bit rd, int a);
        if (!rd) return 0;
        if (a == 0) return 'hFFFF;
        if (a >= 1 && a <= 7) return m_reg[a];
        if (a == 14) return m_reg[7];
        return 0;
    endfunction

    task automatic model_step(bit wr, int a, int d);
        int b;
        bit nxt;
        b = d & 'hFF;
        nxt = 0;
        if (wr) begin
            case (a)
                1: m_feat = b;
                2, 3, 4, 5, 6: m_reg[a] = b;
                7: begin
                    m_cmd = b;
                    if (((m_reg[6] >> 4) & 1) == int'(dev_index) || b == 'h90) nxt = 1;
                end
                14: begin
                    if (((m_dc >> 2) & 1) == 0 && ((b >> 2) & 1) == 1)
                        m_reg[7] = m_reg[7] | 'h80;
                    else if (((m_dc >> 2) & 1) == 1 && ((b >> 2) & 1) == 0)
                        model_reset_regs();
                    m_dc = b;
                end
                default: ;
            endcase
        end
        m_start = nxt;
    endtask

    task automatic check(string tag, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic cycle(string tag, bit rd, bit wr, int a, int d);
        @(negedge clk);
        rd_en = rd; wr_en = wr; addr = 4'(a); wdata = 16'(d);
        #1;
        check(tag, "rdata", int'(rdata), model_read(rd, a));
        check(tag, "cmd_start", int'(cmd_start), int'(m_start));
        check(tag, "cmd_code", int'(cmd_code), m_cmd);
        check(tag, "feat_val", int'(feat_val), m_feat);
        @(posedge clk);
        model_step(wr, a, d);
    endtask

    task automatic rd(string tag, int a);  cycle(tag, 1, 0, a, 0); endtask
    task automatic wr(string tag, int a, int d); cycle(tag, 0, 1, a, d); endtask

    task automatic read_all(string tag);
        for (int a = 0; a < 16; a++) rd(tag, a);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #200000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        model_reset_regs();
        m_dc = 0; m_start = 0;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 power-on values, R2 data, R3 alias, R4 unmapped, R5 error at features address
        read_all("R1");
        rd("R10", 7); cycle("R10", 0, 0, 1, 0); cycle("R10", 0, 0, 0, 0);

        // R6 plain registers
        wr("R6", 2, 'hAB12); wr("R6", 3, 'h5A34); wr("R6", 4, 'hFF00);
        wr("R6", 5, 'h12C3); wr("R6", 6, 'h00A0);
        for (int a = 2; a <= 6; a++) rd("R6", a);

        // R2/R4/R5 writes that must not disturb readable registers
        wr("R2", 0, 'h1234);
        wr("R4", 9, 'h00FF); wr("R4", 15, 'h0004); wr("R4", 8, 'h0090);
        wr("R5", 1, 'h0077);
        read_all("R4");

        // R7 selection: dev_index 0, select bit 0 -> start
        wr("R7", 7, 'h00EC); rd("R7", 7);
        wr("R7", 7, 'h0020); wr("R7", 7, 'h0030); rd("R7", 1);
        // select bit 1 -> not selected except diagnostics
        wr("R7", 6, 'h00B0);
        wr("R7", 7, 'h00EC); rd("R7", 7);
        wr("R7", 7, 'h0090); rd("R7", 7);
        // slave index now matches
        dev_index = 1'b1;
        wr("R7", 7, 'h00C8); rd("R7", 7);
        wr("R7", 6, 'h00A0);
        wr("R7", 7, 'h00C8); wr("R7", 7, 'h0090); rd("R7", 0);
        dev_index = 1'b0;

        // R8 soft reset rise and hold
        wr("R8", 14, 'h0002); rd("R8", 7);
        wr("R8", 14, 'h0004); rd("R8", 7); rd("R3", 14);
        wr("R8", 14, 'h0006); rd("R8", 7); rd("R3", 14);
        wr("R8", 2, 'h0033); wr("R8", 5, 'h0044); wr("R8", 1, 'h0011);
        wr("R8", 7, 'h00E7);
        read_all("R8");

        // R9 release restores everything but control
        wr("R9", 14, 'h0000);
        read_all("R9");
        wr("R9", 14, 'h0004); rd("R9", 7);
        wr("R9", 14, 'h0000); rd("R9", 14);

        // R10 idle bus
        cycle("R10", 0, 0, 14, 0); cycle("R10", 0, 1, 3, 'h0099); rd("R6", 3);

        summary();
    end
endmodule